// File: doc/BRIEF.md
# Serial memory page-write controller

This block is the write side of a two-wire serial memory slave. A separate bit-level front end reports bus events to it, one clock cycle each: a start condition, a finished byte (with its value, at the point where the acknowledge slot is decided), and a stop condition, flagged when the stop cut a byte short. The controller checks the device-select byte, collects a two-byte word address, loads data into a page buffer whose write offset wraps inside the page, and gives an acknowledge decision for every byte.

Two targets share the address space. One is a main array made of 64-byte pages. The other is a register space that holds an 8-byte clock/control page and a single status byte. A proper stop starts a timed internal write cycle that commits the loaded buffer bytes to the chosen page. Writes to protected array pages are acknowledged and then dropped. Writes to the control page are dropped unless the status byte has first received a two-step unlock. A cycle counter stands in for the nonvolatile cell timing. A combinational observation port lets the stored contents be read back for checking.

Top module: `sermem_wr_ctrl`

## Requirements
- R1: The first byte after a start is acknowledged only when bits [7:1] equal DEV_ID and bit 0 is 0. Otherwise it is not acknowledged, and every byte is refused until the next start. A byte that arrives with no start in progress is refused.
- R2: After the select byte, two word-address bytes (high, then low) and any number of data bytes are each acknowledged. High-byte bit 7 set selects register space. In array space the byte address is {high[6:0], low} taken modulo the array size, and the page is that address divided by 64. In register space, a low byte equal to STAT_ADDR (3Fh) targets the status byte, and any other value targets control-page offset low[2:0].
- R3: After each data byte the write offset steps by one and wraps to offset 0 of the same page, after offset 63 for the array and after offset 7 for the control page. The page itself never changes. From offset 60, 30 bytes land at offsets 60..63 and then 0..25.
- R4: When more bytes arrive than the page holds, each later byte overwrites the buffered byte at its offset, in wrap order, so the last byte sent to an offset is the one stored.
- R5: A stop with the midbyte flag low, after at least one data byte, raises busy for exactly WR_CYC cycles. When busy ends, only the offsets that were loaded in the page are changed. All other bytes keep their old values.
- R6: While busy is high, every event is ignored and ack stays 0.
- R7: A stop with the midbyte flag high, or a stop before any data byte, performs no write, raises no busy and leaves all contents unchanged. The next command is served normally.
- R8: With bp_sel = 1, 2 or 3, the array pages at or above 3/4 of the array, at or above 1/2 of the array, or all of them, respectively, are protected. Writes to them are acknowledged byte by byte, but they raise no busy and change nothing, and later commands are still acknowledged.
- R9: The first data byte of a valid write to the status byte sets the unlock state: 02h arms it; 06h while armed or unlocked unlocks it; any other value clears it. A status write raises no busy. A control-page write commits only while unlocked, and otherwise it raises no busy and changes nothing. Unlock persists across control-page writes.
- R10: A start while not busy abandons any partial command, and bytes buffered before it are never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Start condition seen (one-cycle pulse) |
| ev_byte | input | 1 | A full byte was received; ack decision asked this cycle |
| ev_data | input | 8 | Value of the received byte |
| ev_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| ev_midbyte | input | 1 | Qualifies ev_stop: the stop interrupted a byte |
| bp_sel | input | 2 | Block-protect selection for the array |
| ack | output | 1 | Acknowledge decision for the byte in this cycle |
| busy | output | 1 | Internal write cycle in progress |
| obs_reg | input | 1 | Observation select: 1 reads the control page, 0 the array |
| obs_addr | input | AW | Observation byte address (low 3 bits for the control page) |
| obs_data | output | 8 | Observed stored byte |

## Verification
The bench builds the block with eight 64-byte array pages, DEV_ID 57h and a 16-cycle write time. With these values all four protection settings map onto distinct page boundaries (pages 6..7, 4..7, all, none), and every write-cycle length can be counted directly. Short enough page sweeps reach the wrap point on both the 64-byte and the 8-byte page. Overruns of up to 90 bytes exercise the overwrite order. Checking the whole array and the control page after every command shows that untouched bytes and pages keep their values.

// File: rtl/sermem_pkg.sv
// Shared types for the serial memory page-write controller.
package sermem_pkg;
    // Position within one write command on the bus.
    typedef enum logic [2:0] {
        PH_IDLE,  // no command, bytes refused
        PH_DEV,   // expecting device-select byte
        PH_AHI,   // expecting high word-address byte
        PH_ALO,   // expecting low word-address byte
        PH_DATA   // data bytes
    } phase_t;

    // Two-step unlock state for the control page.
    typedef enum logic [1:0] {
        WE_OFF,
        WE_ARMED,
        WE_ON
    } wen_t;
endpackage

// File: rtl/sermem_seq.sv
// Command sequencer: tracks the bus phase, decodes the word address,
// classifies stops, applies block protection and the control-page unlock,
// and times the internal write cycle.
// Assumes at most one event input is high per cycle and that ev_midbyte
// is only meaningful together with ev_stop.
module sermem_seq
    import sermem_pkg::*;
#(
    parameter logic [6:0] DEV_ID      = 7'h57,
    parameter int         ARRAY_PAGES = 8,
    parameter int         PAGE_BYTES  = 64,
    parameter int         WR_CYC      = 16,
    parameter logic [7:0] STAT_ADDR   = 8'h3F,
    localparam int        OFF_W       = $clog2(PAGE_BYTES),
    localparam int        PG_W        = (ARRAY_PAGES > 1) ? $clog2(ARRAY_PAGES) : 1,
    localparam int        CNT_W       = $clog2(WR_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start,
    input  logic             ev_byte,
    input  logic [7:0]       ev_data,
    input  logic             ev_stop,
    input  logic             ev_midbyte,
    input  logic [1:0]       bp_sel,
    output logic             ack,
    output logic             busy,
    output logic             buf_clr,
    output logic             buf_load,
    output logic             buf_set,
    output logic [OFF_W-1:0] start_off,
    output logic             reg_mode,
    output logic [PG_W-1:0]  page,
    output logic             commit,
    output logic             commit_reg
);
    phase_t           ph_q;
    wen_t             wen_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       hi_q, lo_q, first_q;
    logic             got_q;
    logic             sel_ok, is_stat, is_ctl, prot, stop_ok, live;
    logic [14:0]      lin;

    assign busy     = (cnt_q != '0);
    assign live     = !busy;
    assign reg_mode = hi_q[7];
    assign lin      = {hi_q[6:0], lo_q};
    assign page     = lin[OFF_W +: PG_W];
    assign is_stat  = hi_q[7] && (lo_q == STAT_ADDR);
    assign is_ctl   = hi_q[7] && (lo_q != STAT_ADDR);
    assign sel_ok   = (ev_data[7:1] == DEV_ID) && !ev_data[0];
    assign stop_ok  = ev_stop && !ev_midbyte && (ph_q == PH_DATA) && got_q;

    // Protection of the addressed array page from the block-protect field.
    always_comb begin
        case (bp_sel)
            2'd1:    prot = int'(page) >= ARRAY_PAGES - ARRAY_PAGES / 4;
            2'd2:    prot = int'(page) >= ARRAY_PAGES / 2;
            2'd3:    prot = 1'b1;
            default: prot = 1'b0;
        endcase
    end

    // Acknowledge decision for the byte presented this cycle.
    always_comb begin
        ack = 1'b0;
        if (live && ev_byte) begin
            case (ph_q)
                PH_DEV:                   ack = sel_ok;
                PH_AHI, PH_ALO, PH_DATA: ack = 1'b1;
                default:                  ack = 1'b0;
            endcase
        end
    end

    // Page-buffer control strobes.
    assign buf_clr    = (live && ev_start) || commit;
    assign buf_load   = live && ev_byte && (ph_q == PH_DATA);
    assign buf_set    = live && ev_byte && (ph_q == PH_ALO);
    assign start_off  = ev_data[OFF_W-1:0];
    assign commit     = (cnt_q == CNT_W'(1));
    assign commit_reg = hi_q[7];

    // Phase, address capture, unlock state and write-cycle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            wen_q   <= WE_OFF;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            first_q <= '0;
            got_q   <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end else if (ev_start) begin
            ph_q  <= PH_DEV;
            got_q <= 1'b0;
        end else if (ev_stop) begin
            ph_q  <= PH_IDLE;
            got_q <= 1'b0;
            if (stop_ok) begin
                if (is_stat) begin
                    if (first_q == 8'h02)
                        wen_q <= WE_ARMED;
                    else if (first_q == 8'h06 && wen_q != WE_OFF)
                        wen_q <= WE_ON;
                    else
                        wen_q <= WE_OFF;
                end else if (is_ctl) begin
                    if (wen_q == WE_ON) cnt_q <= CNT_W'(WR_CYC);
                end else if (!prot) begin
                    cnt_q <= CNT_W'(WR_CYC);
                end
            end
        end else if (ev_byte) begin
            case (ph_q)
                PH_DEV:  ph_q <= sel_ok ? PH_AHI : PH_IDLE;
                PH_AHI:  begin hi_q <= ev_data; ph_q <= PH_ALO;  end
                PH_ALO:  begin lo_q <= ev_data; ph_q <= PH_DATA; end
                PH_DATA: begin
                    if (!got_q) first_q <= ev_data;
                    got_q <= 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R6: no acknowledge while the write cycle runs.
    p_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack);
    // R5, R7: a write cycle only begins right after a whole-byte stop.
    p_cycle_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(ev_stop) && !$past(ev_midbyte)));
    // R9: a control-page cycle needs the unlocked state.
    p_ctl_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && is_ctl) |-> ($past(wen_q) == WE_ON));
    // R8: an array cycle never starts on a protected page.
    p_prot_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !hi_q[7]) |-> !$past(prot));
    // R3: the addressed page is held while data bytes arrive.
    p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_load |=> $stable(page));
endmodule

// File: rtl/sermem_page_buf.sv
// Page buffer: one byte and one loaded flag per page offset, plus the
// write offset that wraps at the page size (full page for the array,
// REG_BYTES for the control page).
// Assumes buf_set comes before the first buf_load of a command.
module sermem_page_buf #(
    parameter int  PAGE_BYTES = 64,
    parameter int  REG_BYTES  = 8,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int REG_W      = $clog2(REG_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       buf_clr,
    input  logic                       buf_load,
    input  logic                       buf_set,
    input  logic [OFF_W-1:0]           start_off,
    input  logic                       reg_mode,
    input  logic [7:0]                 wdata,
    output logic [PAGE_BYTES-1:0][7:0] buf_data,
    output logic [PAGE_BYTES-1:0]      buf_mask
);
    logic [OFF_W-1:0] off_q, off_nxt, set_val;

    // Next offset: step by one, wrapping inside the active page size.
    always_comb begin
        off_nxt = off_q + OFF_W'(1);
        if (reg_mode) off_nxt = {{(OFF_W-REG_W){1'b0}}, off_q[REG_W-1:0] + REG_W'(1)};
        set_val = reg_mode ? {{(OFF_W-REG_W){1'b0}}, start_off[REG_W-1:0]} : start_off;
    end

    // Offset register: loaded from the low address byte, stepped per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        off_q <= '0;
        else if (buf_set)  off_q <= set_val;
        else if (buf_load) off_q <= off_nxt;
    end

    // Buffer bytes and loaded flags; later bytes overwrite earlier ones.
    always_ff @(posedge clk) begin
        if (!rst_n || buf_clr) begin
            buf_mask <= '0;
        end else if (buf_load) begin
            buf_mask[off_q] <= 1'b1;
        end
        if (!rst_n) buf_data <= '0;
        else if (buf_load) buf_data[off_q] <= wdata;
    end

    // R4: a loaded byte is marked present at the offset it was written to.
    p_load_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_load && !buf_clr) |=> (buf_mask[$past(off_q)] && buf_data[$past(off_q)] == $past(wdata)));
    // R3: on the control page the offset never leaves the 8-byte window.
    p_ctl_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode && buf_load) |=> (int'(off_q) < REG_BYTES));
endmodule

// File: rtl/sermem_store.sv
// Storage model: main array and control page, written from the page
// buffer when the write cycle ends, with a combinational observation port.
// Assumes the page number is steady during commit.
module sermem_store #(
    parameter int  ARRAY_PAGES = 8,
    parameter int  PAGE_BYTES  = 64,
    parameter int  REG_BYTES   = 8,
    localparam int OFF_W       = $clog2(PAGE_BYTES),
    localparam int REG_W       = $clog2(REG_BYTES),
    localparam int PG_W        = (ARRAY_PAGES > 1) ? $clog2(ARRAY_PAGES) : 1,
    localparam int ARR_BYTES   = ARRAY_PAGES * PAGE_BYTES,
    localparam int AW          = $clog2(ARR_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic                       commit_reg,
    input  logic [PG_W-1:0]            page,
    input  logic [PAGE_BYTES-1:0][7:0] buf_data,
    input  logic [PAGE_BYTES-1:0]      buf_mask,
    input  logic                       obs_reg,
    input  logic [AW-1:0]              obs_addr,
    output logic [7:0]                 obs_data
);
    logic [7:0] arr [ARR_BYTES];
    logic [7:0] ctl [REG_BYTES];

    // Main array: cleared on reset, loaded bytes written at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARR_BYTES; i++) arr[i] <= '0;
        end else if (commit && !commit_reg) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (buf_mask[i]) arr[{page, OFF_W'(i)}] <= buf_data[i];
        end
    end

    // Control page: same rule over its smaller window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_BYTES; i++) ctl[i] <= '0;
        end else if (commit && commit_reg) begin
            for (int i = 0; i < REG_BYTES; i++)
                if (buf_mask[i]) ctl[i] <= buf_data[i];
        end
    end

    // Observation read of either storage.
    assign obs_data = obs_reg ? ctl[obs_addr[REG_W-1:0]] : arr[obs_addr];
endmodule

// File: rtl/sermem_wr_ctrl.sv
// Top of the serial memory page-write controller: connects the command
// sequencer, the page buffer and the storage model.
// Assumes the bit-level front end delivers one-cycle event pulses.
module sermem_wr_ctrl #(
    parameter logic [6:0] DEV_ID      = 7'h57,
    parameter int         ARRAY_PAGES = 8,
    parameter int         PAGE_BYTES  = 64,
    parameter int         REG_BYTES   = 8,
    parameter int         WR_CYC      = 16,
    parameter logic [7:0] STAT_ADDR   = 8'h3F,
    localparam int        OFF_W       = $clog2(PAGE_BYTES),
    localparam int        PG_W        = (ARRAY_PAGES > 1) ? $clog2(ARRAY_PAGES) : 1,
    localparam int        AW          = $clog2(ARRAY_PAGES * PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_start,
    input  logic          ev_byte,
    input  logic [7:0]    ev_data,
    input  logic          ev_stop,
    input  logic          ev_midbyte,
    input  logic [1:0]    bp_sel,
    output logic          ack,
    output logic          busy,
    input  logic          obs_reg,
    input  logic [AW-1:0] obs_addr,
    output logic [7:0]    obs_data
);
    logic                       buf_clr, buf_load, buf_set, reg_mode, commit, commit_reg;
    logic [OFF_W-1:0]           start_off;
    logic [PG_W-1:0]            page;
    logic [PAGE_BYTES-1:0][7:0] buf_data;
    logic [PAGE_BYTES-1:0]      buf_mask;

    sermem_seq #(
        .DEV_ID(DEV_ID), .ARRAY_PAGES(ARRAY_PAGES), .PAGE_BYTES(PAGE_BYTES),
        .WR_CYC(WR_CYC), .STAT_ADDR(STAT_ADDR)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_byte(ev_byte),
        .ev_data(ev_data), .ev_stop(ev_stop), .ev_midbyte(ev_midbyte),
        .bp_sel(bp_sel), .ack(ack), .busy(busy), .buf_clr(buf_clr),
        .buf_load(buf_load), .buf_set(buf_set), .start_off(start_off),
        .reg_mode(reg_mode), .page(page), .commit(commit), .commit_reg(commit_reg)
    );

    sermem_page_buf #(.PAGE_BYTES(PAGE_BYTES), .REG_BYTES(REG_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_load(buf_load),
        .buf_set(buf_set), .start_off(start_off), .reg_mode(reg_mode),
        .wdata(ev_data), .buf_data(buf_data), .buf_mask(buf_mask)
    );

    sermem_store #(
        .ARRAY_PAGES(ARRAY_PAGES), .PAGE_BYTES(PAGE_BYTES), .REG_BYTES(REG_BYTES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_reg(commit_reg),
        .page(page), .buf_data(buf_data), .buf_mask(buf_mask),
        .obs_reg(obs_reg), .obs_addr(obs_addr), .obs_data(obs_data)
    );

    // R10: the buffer is empty once a write cycle has finished.
    p_clear_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (buf_mask == '0));
endmodule

// File: tb/tb_sermem_wr_ctrl.sv
`timescale 1ns/1ps
module tb_sermem_wr_ctrl;
    localparam logic [6:0] DEV   = 7'h57;
    localparam int         PAGES = 8;
    localparam int         PB    = 64;
    localparam int         RB    = 8;
    localparam int         WRC   = 16;
    localparam logic [7:0] STAT  = 8'h3F;
    localparam int         ARR   = PAGES * PB;
    localparam int         AW    = $clog2(ARR);

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_start = 0, ev_byte = 0, ev_stop = 0, ev_midbyte = 0;
    logic [7:0] ev_data = '0;
    logic [1:0] bp_sel = '0;
    logic ack, busy, obs_reg = 0;
    logic [AW-1:0] obs_addr = '0;
    logic [7:0] obs_data;

    always #2.5 clk = ~clk;

    sermem_wr_ctrl #(.DEV_ID(DEV), .ARRAY_PAGES(PAGES), .PAGE_BYTES(PB),
        .REG_BYTES(RB), .WR_CYC(WRC), .STAT_ADDR(STAT)) dut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_byte(ev_byte),
        .ev_data(ev_data), .ev_stop(ev_stop), .ev_midbyte(ev_midbyte),
        .bp_sel(bp_sel), .ack(ack), .busy(busy), .obs_reg(obs_reg),
        .obs_addr(obs_addr), .obs_data(obs_data));

    int checks = 0, errors = 0;
    logic [7:0] mem_m [ARR];
    logic [7:0] ctl_m [RB];
    int wen_m = 0;  // 0 off, 1 armed, 2 unlocked

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit prot_f(input int bp, input int pg);
        case (bp)
            1: return pg >= PAGES - PAGES / 4;
            2: return pg >= PAGES / 2;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_start();
        @(negedge clk); ev_start = 1;
        @(negedge clk); ev_start = 0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic a);
        @(negedge clk); ev_byte = 1; ev_data = d;
        #1 a = ack;
        @(negedge clk); ev_byte = 0;
    endtask

    task automatic send_stop(input bit mid);
        @(negedge clk); ev_stop = 1; ev_midbyte = mid;
        @(negedge clk); ev_stop = 0; ev_midbyte = 0;
    endtask

    task automatic count_busy(output int c);
        c = 0;
        while (busy && c < 1000) begin c++; @(negedge clk); end
    endtask

    task automatic cmp_all(input string req);
        int bad = 0, fa = 0, fv = 0, fe = 0;
        for (int i = 0; i < ARR; i++) begin
            obs_reg = 0; obs_addr = AW'(i); #1;
            if (obs_data !== mem_m[i]) begin
                if (bad == 0) begin fa = i; fv = obs_data; fe = mem_m[i]; end
                bad++;
            end
        end
        for (int i = 0; i < RB; i++) begin
            obs_reg = 1; obs_addr = AW'(i); #1;
            if (obs_data !== ctl_m[i]) begin
                if (bad == 0) begin fa = 1000 + i; fv = obs_data; fe = ctl_m[i]; end
                bad++;
            end
        end
        obs_reg = 0;
        if (bad != 0) $display("  first mismatch at %0d (ctl if >=1000)", fa);
        check(bad == 0, req, fv, fe);
    endtask

    // Full write command with model update. fb >= 0 fixes the first data byte.
    task automatic op(input bit regsp, input logic [6:0] hi7, input logic [7:0] lo,
                      input int n, input int bp, input bit mid, input int fb,
                      input string req);
        logic a;
        logic [7:0] hi, d, first;
        logic [7:0] tbuf [PB];
        bit tmask [PB];
        int badack = 0, off, pg, c;
        bit stat, exp_busy;
        hi = {regsp, hi7};
        first = 0;
        for (int i = 0; i < PB; i++) begin tbuf[i] = 0; tmask[i] = 0; end
        bp_sel = 2'(bp);
        send_start();
        send_byte({DEV, 1'b0}, a); if (!a) badack++;
        send_byte(hi, a);          if (!a) badack++;
        send_byte(lo, a);          if (!a) badack++;
        for (int k = 0; k < n; k++) begin
            d = (k == 0 && fb >= 0) ? 8'(fb) : 8'($urandom);
            send_byte(d, a); if (!a) badack++;
            if (k == 0) first = d;
            off = regsp ? (int'(lo[2:0]) + k) % RB : (int'(lo[5:0]) + k) % PB;
            tbuf[off] = d; tmask[off] = 1;
        end
        check(badack == 0, {req, " R2 acks"}, badack, 0);
        send_stop(mid);
        count_busy(c);
        pg = int'({hi7, lo}) / PB % PAGES;
        stat = regsp && lo == STAT;
        exp_busy = 0;
        if (!mid && n > 0) begin
            if (stat) begin
                if (first == 8'h02) wen_m = 1;
                else if (first == 8'h06 && wen_m != 0) wen_m = 2;
                else wen_m = 0;
            end else if (regsp) begin
                exp_busy = (wen_m == 2);
            end else begin
                exp_busy = !prot_f(bp, pg);
            end
        end
        if (exp_busy)
            for (int i = 0; i < PB; i++)
                if (tmask[i]) begin
                    if (regsp) ctl_m[i] = tbuf[i];
                    else mem_m[pg * PB + i] = tbuf[i];
                end
        check(c == (exp_busy ? WRC : 0), {req, " R5 busy length"}, c, exp_busy ? WRC : 0);
        cmp_all({req, " R5 contents"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a;
        int c;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < ARR; i++) mem_m[i] = 0;
        for (int i = 0; i < RB; i++) ctl_m[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        check(busy == 0, "R5 reset busy", busy, 0);
        check(ack == 0, "R6 reset ack", ack, 0);
        cmp_all("R5 reset contents");

        // R1: select byte checks
        send_start();
        send_byte({7'h56, 1'b0}, a); check(a == 0, "R1 wrong id", a, 0);
        send_byte(8'h00, a);         check(a == 0, "R1 after refusal", a, 0);
        send_stop(0);
        send_start();
        send_byte({DEV, 1'b1}, a);   check(a == 0, "R1 read bit", a, 0);
        send_stop(0);
        send_byte({DEV, 1'b0}, a);   check(a == 0, "R1 no start", a, 0);

        // R3: offset 60, 30 bytes on array page 2 (address 0x0BC)
        op(0, 7'h00, 8'hBC, 30, 0, 0, -1, "R3 wrap 64");
        // R4: 90 bytes from offset 10 on page 5 overrun the page
        op(0, 7'h01, 8'h4A, 90, 0, 0, -1, "R4 overrun");

        // R6: events during a write cycle are refused
        bp_sel = 0;
        send_start();
        send_byte({DEV, 1'b0}, a); send_byte(8'h00, a); send_byte(8'h05, a);
        send_byte(8'hA5, a);
        send_stop(0);
        mem_m[5] = 8'hA5;
        send_start();
        send_byte({DEV, 1'b0}, a); check(a == 0, "R6 ack while busy", a, 0);
        check(busy == 1, "R6 still busy", busy, 1);
        send_stop(0);
        count_busy(c);
        cmp_all("R6 contents after busy");

        // R7: midbyte stop and stop before data
        op(0, 7'h00, 8'h20, 5, 0, 1, -1, "R7 midbyte stop");
        op(0, 7'h00, 8'h20, 0, 0, 0, -1, "R7 no data");

        // R8: protection settings
        op(0, 7'h00, 8'h40, 4, 3, 0, -1, "R8 bp3 all");
        op(0, 7'h01, 8'hC0, 4, 1, 0, -1, "R8 bp1 page7");
        op(0, 7'h01, 8'h40, 4, 1, 0, -1, "R8 bp1 page5 open");
        op(0, 7'h01, 8'h00, 4, 2, 0, -1, "R8 bp2 page4");
        op(0, 7'h00, 8'hC0, 4, 2, 0, -1, "R8 bp2 page3 open");

        // R9: control page unlock sequence
        op(1, 7'h00, 8'h02, 3, 0, 0, -1, "R9 locked ctl");
        op(1, 7'h00, STAT, 1, 0, 0, 8'h06, "R9 06 without 02");
        op(1, 7'h00, 8'h02, 3, 0, 0, -1, "R9 still locked");
        op(1, 7'h00, STAT, 1, 0, 0, 8'h02, "R9 arm");
        op(1, 7'h00, STAT, 1, 0, 0, 8'h06, "R9 unlock");
        op(1, 7'h00, 8'h06, 11, 0, 0, -1, "R9 R3 ctl wrap 8");
        op(1, 7'h00, 8'h01, 2, 0, 0, -1, "R9 unlock persists");
        op(1, 7'h00, STAT, 1, 0, 0, 8'h02, "R9 rearm");
        op(1, 7'h00, STAT, 1, 0, 0, 8'h05, "R9 clear");
        op(1, 7'h00, 8'h00, 2, 0, 0, -1, "R9 relocked");

        // R10: restart abandons buffered bytes
        bp_sel = 0;
        send_start();
        send_byte({DEV, 1'b0}, a); send_byte(8'h00, a); send_byte(8'h80, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
        op(0, 7'h00, 8'h90, 1, 0, 0, -1, "R10 restart");

        // Random mix
        for (int it = 0; it < 40; it++) begin
            int kind = int'($urandom % 10);
            logic [7:0] lo = 8'($urandom);
            logic [6:0] hi = 7'($urandom);
            int n = 1 + int'($urandom % 90);
            int bp = int'($urandom % 4);
            if (kind < 6)       op(0, hi, lo, n, bp, 0, -1, "R5 random array");
            else if (kind == 6) op(1, 7'h00, {lo[7:6] == 2'b11 ? 2'b00 : lo[7:6], lo[5:0]} == STAT ? 8'h00 : lo & 8'h07, 1 + n % 12, 0, 0, -1, "R9 random ctl");
            else if (kind < 9)  op(1, 7'h00, STAT, 1, 0, 0, (kind == 7) ? 8'h02 : 8'h06, "R9 random status");
            else                op(0, hi, lo, n, bp, int'($urandom % 2) == 1, -1, "R7 random stop");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule